// File: doc/BRIEF.md
# Debug data transfer channel

This block is a two-way 32-bit mailbox between an external debugger and a processor. The debugger reaches it over a small register bus. A write to one fixed offset fills the receive data register, and a read of another fixed offset drains the transmit data register. The processor uses a write port and a read port that are either 32 or 64 bits wide. A 64-bit access treats the two data registers as one half-duplex channel.

Each direction has a full flag. Faults are recorded in sticky flags: a receive overrun, a transmit underrun, and a common error flag. While the error flag is set, debugger accesses cause no side effects. A write-one-to-clear control register clears the sticky flags. A debugger access is refused with an error response unless the power status is up and both lock inputs are clear. A memory-mapped access made while the software lock is set is ignored for writes and has no side effects for reads.

Both request sides are valid-only and never stall. A request is accepted in every cycle where its valid is high. Its response comes back exactly one cycle later on a response-valid strobe. No ready signal exists, so the requester must be able to take the response in that cycle. One level-sensitive interrupt combines the two flag conditions under two enable inputs.

Top module: `dbg_mailbox`

## Requirements
- R1: A debugger write to offset 0x08C loads the receive register and sets receive-full. A debugger read of 0x08C returns the receive register. A debugger read of 0x080 returns the transmit register and clears transmit-full. Every debugger request gets `dbg_rsp_valid` one cycle later.
- R2: If `pwr_up` is 0, or `dbg_lock` is 1, or `os_lock` is 1, a debugger access returns `dbg_rsp_err`=1 with zero data and changes no state.
- R3: While the sticky error flag is set, a debugger write to 0x08C is ignored. A read of 0x080 still returns the transmit data (zero when transmit-full is clear) and changes no flag.
- R4: A debugger access with `dbg_mmap`=1 while `sw_lock`=1 changes no state, although a read still returns data. The same access with `dbg_mmap`=0 is unaffected by the lock.
- R5: A debugger write to 0x08C while receive-full is set is dropped. It sets the receive-overrun flag and the error flag.
- R6: A debugger read of 0x080 while transmit-full is clear returns zero and sets the transmit-underrun flag and the error flag.
- R7: A processor 32-bit write stores bits 31:0 in the transmit register. A 64-bit write stores bits 63:32 in the receive register and bits 31:0 in the transmit register. Both widths set transmit-full. A write made while transmit-full is set is discarded.
- R8: A processor read answers one cycle later on `cpu_rd_rsp_valid`. A 64-bit read returns {transmit, receive} and a 32-bit read returns {zero, receive}. The result is zero if receive-full was clear. Any processor read clears receive-full.
- R9: `irq` is high exactly when (receive-full and `irq_rx_en`) or (transmit-full clear and `irq_tx_en`).
- R10: Offset 0x088 is a control register. Writing 1 to bit 0 clears the error flag, bit 1 clears receive-overrun, and bit 2 clears transmit-underrun. A read returns {underrun, overrun, error, transmit-full, receive-full} in bits 4:0. Other offsets read zero with no error, and writes to them are ignored.
- R11: Reset clears every flag and both data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_valid | input | 1 | Debugger request strobe |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | ADDR_W | Register offset |
| dbg_wdata | input | DW | Write data |
| dbg_mmap | input | 1 | Request arrived through the memory-mapped path |
| pwr_up | input | 1 | Core power status is up |
| dbg_lock | input | 1 | Debug lock held |
| os_lock | input | 1 | OS lock held |
| sw_lock | input | 1 | Software lock held |
| dbg_rsp_valid | output | 1 | Debugger response strobe |
| dbg_rsp_err | output | 1 | Error response |
| dbg_rsp_data | output | DW | Read data |
| cpu_wr_valid | input | 1 | Processor write strobe |
| cpu_wr_wide | input | 1 | 1 = 64-bit write |
| cpu_wr_data | input | 2*DW | Processor write data |
| cpu_rd_valid | input | 1 | Processor read strobe |
| cpu_rd_wide | input | 1 | 1 = 64-bit read |
| cpu_rd_rsp_valid | output | 1 | Processor read response strobe |
| cpu_rd_rsp_data | output | 2*DW | Processor read data |
| irq_rx_en | input | 1 | Interrupt enable for receive-full |
| irq_tx_en | input | 1 | Interrupt enable for transmit-empty |
| irq | output | 1 | Combined interrupt level |

## Verification
The assertions assume that a debugger receive-register write and a 64-bit processor write never fall in the same cycle. Both would load the receive register, and in that case the debugger data wins. The flag assertions also assume the permission and lock inputs are steady during a request cycle. The stimulus issues exactly one operation per transaction, on one side at a time, and holds the permission and lock levels for the whole transaction. The randomly drawn denied accesses, software-locked accesses and flag clears therefore stay within those assumptions.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

  // Register offsets seen by the debugger (fixed by the block's behaviour)
  localparam logic [11:0] OFS_TXDATA = 12'h080;
  localparam logic [11:0] OFS_CTRL   = 12'h088;
  localparam logic [11:0] OFS_RXDATA = 12'h08C;

  // Write-one-to-clear bit positions in the control register
  localparam int CLR_ERR_BIT = 0;
  localparam int CLR_OVR_BIT = 1;
  localparam int CLR_UDR_BIT = 2;
  localparam int CLR_BITS    = 3;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RX_WR,
    OP_RX_RD,
    OP_TX_RD,
    OP_CTL_WR,
    OP_CTL_RD,
    OP_OTHER
  } dbg_op_e;

  // Packed so that the control-register read image is {udr, ovr, err, txf, rxf}
  typedef struct packed {
    logic tx_udr;
    logic rx_ovr;
    logic err;
    logic tx_full;
    logic rx_full;
  } mb_flags_t;

  localparam int FLAG_W = $bits(mb_flags_t);

endpackage

// File: rtl/dbgmb_decode.sv
module dbgmb_decode
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_mmap,
  input  logic              pwr_up,
  input  logic              dbg_lock,
  input  logic              os_lock,
  input  logic              sw_lock,
  output dbg_op_e           op,
  output logic              deny,
  output logic              locked
);

  logic allowed;
  logic hit_tx, hit_rx, hit_ctl;

  assign allowed = pwr_up && !dbg_lock && !os_lock;
  assign deny    = req_valid && !allowed;
  assign locked  = req_mmap && sw_lock;

  assign hit_tx  = (req_addr == ADDR_W'(OFS_TXDATA));
  assign hit_rx  = (req_addr == ADDR_W'(OFS_RXDATA));
  assign hit_ctl = (req_addr == ADDR_W'(OFS_CTRL));

  always_comb begin
    op = OP_NONE;
    if (req_valid && allowed) begin
      if (hit_rx)       op = req_write ? OP_RX_WR  : OP_RX_RD;
      else if (hit_tx)  op = req_write ? OP_OTHER  : OP_TX_RD;
      else if (hit_ctl) op = req_write ? OP_CTL_WR : OP_CTL_RD;
      else              op = OP_OTHER;
    end
  end

endmodule

// File: rtl/dbgmb_flags.sv
module dbgmb_flags
  import dbgmb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  dbg_op_e             op,
  input  logic                locked,
  input  logic [CLR_BITS-1:0] clr_bits,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  output mb_flags_t           flags,
  output logic                rx_load,
  output logic                cpu_wr_take
);

  mb_flags_t flag_r, flag_n;
  logic side_ok, rx_over, tx_pop, tx_under, ctl_clr;

  assign side_ok     = !flag_r.err && !locked;
  assign rx_load     = (op == OP_RX_WR) && side_ok && !flag_r.rx_full;
  assign rx_over     = (op == OP_RX_WR) && side_ok &&  flag_r.rx_full;
  assign tx_pop      = (op == OP_TX_RD) && side_ok &&  flag_r.tx_full;
  assign tx_under    = (op == OP_TX_RD) && side_ok && !flag_r.tx_full;
  assign ctl_clr     = (op == OP_CTL_WR) && !locked;
  assign cpu_wr_take = cpu_wr && !flag_r.tx_full;

  always_comb begin
    flag_n = flag_r;
    // receive-full: debugger load wins over a same-cycle processor drain
    if (rx_load)     flag_n.rx_full = 1'b1;
    else if (cpu_rd) flag_n.rx_full = 1'b0;
    // transmit-full: an accepted processor write wins over a debugger pop
    if (cpu_wr_take) flag_n.tx_full = 1'b1;
    else if (tx_pop) flag_n.tx_full = 1'b0;
    // sticky flags: clear first, a new fault sets again
    if (ctl_clr && clr_bits[CLR_ERR_BIT]) flag_n.err    = 1'b0;
    if (ctl_clr && clr_bits[CLR_OVR_BIT]) flag_n.rx_ovr = 1'b0;
    if (ctl_clr && clr_bits[CLR_UDR_BIT]) flag_n.tx_udr = 1'b0;
    if (rx_over)  begin flag_n.rx_ovr = 1'b1; flag_n.err = 1'b1; end
    if (tx_under) begin flag_n.tx_udr = 1'b1; flag_n.err = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_r <= '0;
    else        flag_r <= flag_n;
  end

  assign flags = flag_r;

endmodule

// File: rtl/dbgmb_data.sv
module dbgmb_data #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_load,
  input  logic [DW-1:0] dbg_wdata,
  input  logic          cpu_wr_take,
  input  logic          cpu_wr_wide,
  input  logic [2*DW-1:0] cpu_wr_data,
  input  logic          cpu_rd,
  input  logic          cpu_rd_wide,
  input  logic          rx_full,
  output logic [DW-1:0] rx_q,
  output logic [DW-1:0] tx_q,
  output logic          rsp_valid,
  output logic [2*DW-1:0] rsp_data
);

  logic [2*DW-1:0] rd_image;

  // Receive register: debugger load has priority over the upper half of a wide write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rx_q <= '0;
    else if (rx_load)                    rx_q <= dbg_wdata;
    else if (cpu_wr_take && cpu_wr_wide) rx_q <= cpu_wr_data[2*DW-1:DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_q <= '0;
    else if (cpu_wr_take) tx_q <= cpu_wr_data[DW-1:0];
  end

  // Read word order is the reverse of the write order
  always_comb begin
    if (!rx_full)         rd_image = '0;
    else if (cpu_rd_wide) rd_image = {tx_q, rx_q};
    else                  rd_image = {{DW{1'b0}}, rx_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cpu_rd;
      rsp_data  <= cpu_rd ? rd_image : '0;
    end
  end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_valid,
  input  logic              dbg_write,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DW-1:0]     dbg_wdata,
  input  logic              dbg_mmap,
  input  logic              pwr_up,
  input  logic              dbg_lock,
  input  logic              os_lock,
  input  logic              sw_lock,
  output logic              dbg_rsp_valid,
  output logic              dbg_rsp_err,
  output logic [DW-1:0]     dbg_rsp_data,
  input  logic              cpu_wr_valid,
  input  logic              cpu_wr_wide,
  input  logic [2*DW-1:0]   cpu_wr_data,
  input  logic              cpu_rd_valid,
  input  logic              cpu_rd_wide,
  output logic              cpu_rd_rsp_valid,
  output logic [2*DW-1:0]   cpu_rd_rsp_data,
  input  logic              irq_rx_en,
  input  logic              irq_tx_en,
  output logic              irq
);

  dbg_op_e   op;
  logic      deny, locked, rx_load, cpu_wr_take;
  mb_flags_t flag_q;
  logic [DW-1:0] rx_q, tx_q, rd_mux;

  dbgmb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (dbg_valid),
    .req_write (dbg_write),
    .req_addr  (dbg_addr),
    .req_mmap  (dbg_mmap),
    .pwr_up    (pwr_up),
    .dbg_lock  (dbg_lock),
    .os_lock   (os_lock),
    .sw_lock   (sw_lock),
    .op        (op),
    .deny      (deny),
    .locked    (locked)
  );

  dbgmb_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .locked      (locked),
    .clr_bits    (dbg_wdata[CLR_BITS-1:0]),
    .cpu_wr      (cpu_wr_valid),
    .cpu_rd      (cpu_rd_valid),
    .flags       (flag_q),
    .rx_load     (rx_load),
    .cpu_wr_take (cpu_wr_take)
  );

  dbgmb_data #(.DW(DW)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_load     (rx_load),
    .dbg_wdata   (dbg_wdata),
    .cpu_wr_take (cpu_wr_take),
    .cpu_wr_wide (cpu_wr_wide),
    .cpu_wr_data (cpu_wr_data),
    .cpu_rd      (cpu_rd_valid),
    .cpu_rd_wide (cpu_rd_wide),
    .rx_full     (flag_q.rx_full),
    .rx_q        (rx_q),
    .tx_q        (tx_q),
    .rsp_valid   (cpu_rd_rsp_valid),
    .rsp_data    (cpu_rd_rsp_data)
  );

  // Debugger read data: empty transmit register reads as zero
  always_comb begin
    unique case (op)
      OP_RX_RD:  rd_mux = rx_q;
      OP_TX_RD:  rd_mux = flag_q.tx_full ? tx_q : '0;
      OP_CTL_RD: rd_mux = DW'(flag_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_rsp_valid <= 1'b0;
      dbg_rsp_err   <= 1'b0;
      dbg_rsp_data  <= '0;
    end else begin
      dbg_rsp_valid <= dbg_valid;
      dbg_rsp_err   <= deny;
      dbg_rsp_data  <= rd_mux;
    end
  end

  assign irq = (flag_q.rx_full && irq_rx_en) || (!flag_q.tx_full && irq_tx_en);

endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_valid,
  input logic              dbg_write,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic [DW-1:0]     dbg_wdata,
  input logic              dbg_mmap,
  input logic              pwr_up,
  input logic              dbg_lock,
  input logic              os_lock,
  input logic              sw_lock,
  input logic              dbg_rsp_valid,
  input logic              dbg_rsp_err,
  input logic [DW-1:0]     dbg_rsp_data,
  input logic              cpu_wr_valid,
  input logic              cpu_rd_valid,
  input logic              cpu_rd_rsp_valid,
  input logic [2*DW-1:0]   cpu_rd_rsp_data,
  input logic              irq_rx_en,
  input logic              irq_tx_en,
  input logic              irq,
  input mb_flags_t         flag_q
);

  logic perm, open_req;
  assign perm     = pwr_up && !dbg_lock && !os_lock;
  assign open_req = dbg_valid && perm && !flag_q.err && !(dbg_mmap && sw_lock);

  assert_deny_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_valid && !perm |=> dbg_rsp_valid && dbg_rsp_err && (dbg_rsp_data == '0));

  assert_deny_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_valid && !perm && !cpu_wr_valid && !cpu_rd_valid |=> $stable(flag_q));

  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    open_req && dbg_write && dbg_addr == ADDR_W'(OFS_RXDATA) && flag_q.rx_full
    |=> flag_q.rx_ovr && flag_q.err);

  assert_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    open_req && !dbg_write && dbg_addr == ADDR_W'(OFS_TXDATA) && !flag_q.tx_full
    |=> flag_q.tx_udr && flag_q.err && (dbg_rsp_data == '0));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q.err) |-> $past(dbg_valid && dbg_write && perm &&
                                dbg_addr == ADDR_W'(OFS_CTRL) && dbg_wdata[CLR_ERR_BIT]));

  assert_rd_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_valid && flag_q.rx_full |=> !flag_q.rx_full);

  assert_rd_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_valid && !flag_q.rx_full |=> cpu_rd_rsp_valid && (cpu_rd_rsp_data == '0));

  assert_wr_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid && !flag_q.tx_full |=> flag_q.tx_full);

  assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q.rx_full && irq_rx_en) || (!flag_q.tx_full && irq_tx_en) |-> irq);

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_rx_en && flag_q.rx_full) || (irq_tx_en && !flag_q.tx_full));

endmodule

bind dbg_mailbox dbg_mailbox_chk #(.ADDR_W(ADDR_W), .DW(DW)) chk_i (.*);

// File: tb/dbg_mailbox_tb_top.sv
`timescale 1ns/1ps
module dbg_mailbox_tb_top;

  localparam logic [11:0] A_TX = 12'h080;
  localparam logic [11:0] A_CT = 12'h088;
  localparam logic [11:0] A_RX = 12'h08C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        dbg_valid = 0, dbg_write = 0, dbg_mmap = 0;
  logic [11:0] dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic        pwr_up = 1, dbg_lock = 0, os_lock = 0, sw_lock = 0;
  logic        dbg_rsp_valid, dbg_rsp_err;
  logic [31:0] dbg_rsp_data;
  logic        cpu_wr_valid = 0, cpu_wr_wide = 0, cpu_rd_valid = 0, cpu_rd_wide = 0;
  logic [63:0] cpu_wr_data = '0;
  logic        cpu_rd_rsp_valid;
  logic [63:0] cpu_rd_rsp_data;
  logic        irq_rx_en = 0, irq_tx_en = 0, irq;

  dbg_mailbox dut_i (.*);

  int n_chk = 0, n_bad = 0;
  // bench model of the mailbox state
  logic [31:0] m_rx = 0, m_tx = 0;
  bit m_rxf = 0, m_txf = 0, m_err = 0, m_ovr = 0, m_udr = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dbg_op(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit mm, input string req);
    logic [31:0] exp_d;
    bit deny, lk, ok, exp_e;
    @(negedge clk);
    dbg_valid = 1; dbg_write = wr; dbg_addr = a; dbg_wdata = d; dbg_mmap = mm;
    deny = !pwr_up || dbg_lock || os_lock;
    lk = mm && sw_lock;
    ok = !deny && !m_err && !lk;
    exp_d = 0; exp_e = deny;
    if (!deny) begin
      if (a == A_RX) begin
        if (!wr) exp_d = m_rx;
        else if (ok) begin
          if (m_rxf) begin m_ovr = 1; m_err = 1; end
          else begin m_rx = d; m_rxf = 1; end
        end
      end else if (a == A_TX && !wr) begin
        exp_d = m_txf ? m_tx : 32'd0;
        if (ok) begin
          if (m_txf) m_txf = 0;
          else begin m_udr = 1; m_err = 1; end
        end
      end else if (a == A_CT) begin
        if (!wr) exp_d = {27'd0, m_udr, m_ovr, m_err, m_txf, m_rxf};
        else if (!lk) begin
          if (d[0]) m_err = 0;
          if (d[1]) m_ovr = 0;
          if (d[2]) m_udr = 0;
        end
      end
    end
    @(negedge clk);
    dbg_valid = 0;
    chk(dbg_rsp_valid === 1'b1 && dbg_rsp_err === exp_e && dbg_rsp_data === exp_d, req,
        {31'd0, dbg_rsp_err, dbg_rsp_data}, {31'd0, exp_e, exp_d});
  endtask

  task automatic flags_chk(input string req);
    logic sp = pwr_up, sd = dbg_lock, so = os_lock;
    pwr_up = 1; dbg_lock = 0; os_lock = 0;
    dbg_op(0, A_CT, 0, 0, req);
    pwr_up = sp; dbg_lock = sd; os_lock = so;
  endtask

  task automatic cpu_wr(input bit wide, input logic [63:0] d);
    @(negedge clk);
    cpu_wr_valid = 1; cpu_wr_wide = wide; cpu_wr_data = d;
    if (!m_txf) begin
      if (wide) m_rx = d[63:32];
      m_tx = d[31:0];
      m_txf = 1;
    end
    @(negedge clk);
    cpu_wr_valid = 0;
  endtask

  task automatic cpu_rd(input bit wide, input string req);
    logic [63:0] exp_d;
    @(negedge clk);
    cpu_rd_valid = 1; cpu_rd_wide = wide;
    exp_d = !m_rxf ? 64'd0 : (wide ? {m_tx, m_rx} : {32'd0, m_rx});
    m_rxf = 0;
    @(negedge clk);
    cpu_rd_valid = 0;
    chk(cpu_rd_rsp_valid === 1'b1 && cpu_rd_rsp_data === exp_d, req, cpu_rd_rsp_data, exp_d);
  endtask

  task automatic irq_chk();
    bit e = (m_rxf && irq_rx_en) || (!m_txf && irq_tx_en);
    chk(irq === e, "R9 irq level", {63'd0, irq}, {63'd0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    flags_chk("R11 flags after reset");
    dbg_op(0, A_RX, 0, 0, "R11 receive register after reset");
    irq_chk();
    cpu_rd(1, "R11 processor read after reset");
    // R1 basic transfers
    dbg_op(1, A_RX, 32'hA5A5_0001, 1, "R1 receive write");
    flags_chk("R1 receive-full set");
    cpu_rd(0, "R8 narrow read of receive");
    cpu_wr(0, 64'hFFFF_0000_0000_1234);
    dbg_op(0, A_TX, 0, 1, "R1 transmit read");
    flags_chk("R1 transmit-full cleared");
    // R5 overrun
    dbg_op(1, A_RX, 32'h1111_1111, 0, "R5 first write");
    dbg_op(1, A_RX, 32'h2222_2222, 0, "R5 second write");
    flags_chk("R5 overrun and error set");
    cpu_rd(0, "R5 first value kept");
    // R3 sticky error blocks side effects
    dbg_op(1, A_RX, 32'h3333_3333, 0, "R3 write with error");
    flags_chk("R3 receive-full unchanged");
    cpu_wr(0, 64'h77);
    dbg_op(0, A_TX, 0, 0, "R3 read returns data with error");
    flags_chk("R3 transmit-full kept");
    // R10 clear and unmapped
    dbg_op(1, A_CT, 32'h7, 0, "R10 clear write");
    flags_chk("R10 sticky flags cleared");
    dbg_op(0, 12'h000, 0, 0, "R10 unmapped read");
    // R6 underrun
    dbg_op(0, A_TX, 0, 0, "R6 pop full");
    dbg_op(0, A_TX, 0, 0, "R6 underrun read");
    flags_chk("R6 underrun and error set");
    dbg_op(1, A_CT, 32'h7, 0, "R10 clear after underrun");
    // R4 software lock
    sw_lock = 1;
    dbg_op(1, A_RX, 32'h4444_4444, 1, "R4 locked memory-mapped write");
    flags_chk("R4 no receive-full");
    dbg_op(1, A_RX, 32'h5555_5555, 0, "R4 unlocked path write");
    flags_chk("R4 receive-full via other path");
    sw_lock = 0;
    cpu_rd(0, "R4 value from unlocked path");
    // R2 permission
    os_lock = 1;
    dbg_op(1, A_RX, 32'h6666_6666, 0, "R2 os lock write");
    os_lock = 0; pwr_up = 0;
    dbg_op(0, A_TX, 0, 0, "R2 power down read");
    pwr_up = 1; dbg_lock = 1;
    dbg_op(1, A_CT, 32'h7, 0, "R2 debug lock control write");
    dbg_lock = 0;
    flags_chk("R2 flags unchanged");
    // R7 wide write and discard when full
    cpu_wr(1, 64'hCAFE_0001_BEEF_0002);
    dbg_op(0, A_RX, 0, 0, "R7 upper half in receive");
    cpu_wr(0, 64'h9999);
    dbg_op(0, A_TX, 0, 0, "R7 lower half kept, later write discarded");
    // R8 wide read order
    cpu_wr(0, 64'hABCD);
    dbg_op(1, A_RX, 32'h0101_0101, 0, "R8 load receive");
    cpu_rd(1, "R8 wide read order");
    cpu_rd(1, "R8 empty read is zero");
    // R9 interrupt enables
    irq_rx_en = 1; irq_tx_en = 0; #1 irq_chk();
    irq_rx_en = 0; irq_tx_en = 1; #1 irq_chk();
    dbg_op(0, A_TX, 0, 0, "R9 drain transmit");
    irq_chk();
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom % 16);
      pwr_up = ($urandom % 12) != 0;
      sw_lock = ($urandom % 5) == 0;
      irq_rx_en = $urandom % 2;
      irq_tx_en = $urandom % 2;
      if (r < 3)       dbg_op(1, A_RX, $urandom, $urandom % 2, "R1 random receive write");
      else if (r < 6)  dbg_op(0, A_TX, 0, $urandom % 2, "R6 random transmit read");
      else if (r == 6) dbg_op(0, A_RX, 0, 0, "R1 random receive read");
      else if (r == 7) dbg_op(0, A_CT, 0, 0, "R10 random flag read");
      else if (r == 8) dbg_op(1, A_CT, $urandom % 8, $urandom % 2, "R10 random clear");
      else if (r < 11) cpu_wr(0, {$urandom, $urandom});
      else if (r < 13) cpu_wr(1, {$urandom, $urandom});
      else             cpu_rd($urandom % 2, "R8 random processor read");
      irq_chk();
    end
    pwr_up = 1; sw_lock = 0;
    flags_chk("R10 final flags");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule